// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one instruction operand into something the execute stage can use directly. A mode code and a slot flag select the mode. The slot flag says whether the operand is the first or the second of an instruction. Depending on the mode, the block returns one of three things:

- nothing, for the implied mode;
- a value, which is the literal or a register's contents;
- an address, which is a constant, a register, or a sum of a base register, a scaled index register, an offset and a displacement.

For the memory-indirect mode the block reads a pointer word from memory first, and that word becomes the operand address.

Register contents arrive on two combinational read ports. The constant, the scale code and the displacement come with the start pulse. Memory is reached through a request/ready read port that is held until it is served. While that read is in progress, the block reports busy and ignores new starts. Every successful resolution ends in a one-cycle done pulse that carries a kind code and a 64-bit result. A code that the first operand slot cannot hold ends in an illegal pulse instead.

Top module: `operand_ea_gen`

## Requirements
- R1: In the cycle after reset is released, `done`, `illegal`, `mem_req` and `busy` are all 0.
- R2: The first slot (`second_slot`=0) decodes only `mode_code[1:0]`: 0 register, 1 pointer, 2 indexed, 3 scaled. The second slot (`second_slot`=1) decodes all three bits: 0 implied, 1 immediate, 2 absolute, 3 register, 4 memory-indirect, 5 pointer, 6 indexed, 7 displaced.
- R3: Implied mode gives `done`=1 one cycle after the accepted start, with `kind`=0 (none) and `result`=0.
- R4: Immediate mode gives `kind`=1 (value) and absolute mode gives `kind`=2 (address). In both modes `result` equals `konst`, one cycle after start.
- R5: Register mode returns the base register's contents with `kind`=1. Pointer mode returns the same contents with `kind`=2. The base register is selected through `rf_addr_a`=`base_sel`.
- R6: Indexed mode returns the address base register + `konst` with `kind`=2, wrapping modulo 2^64.
- R7: Scaled mode returns base + (index << `scale_code`) with `kind`=2. Scale codes 0 to 3 multiply the index register by 1, 2, 4 and 8. The index register is selected through `rf_addr_b`=`index_sel`.
- R8: Displaced mode returns base + (index << `scale_code`) + `disp` with `kind`=2, wrapping modulo 2^64.
- R9: Memory-indirect mode raises `mem_req` with `mem_addr`=`konst` one cycle after start. Both stay steady until `mem_ready` is sampled high. One cycle after that, `done`=1, `kind`=2 and `result` is the word read.
- R10: On the first slot, codes 4 to 7 give `illegal`=1 one cycle after start, with `done`=0 and no memory request.
- R11: While `busy`=1, a start has no effect: no done, and the pending request and its address are unchanged.
- R12: `done` and `illegal` are never high together, and each lasts one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Resolve the operand described by the other inputs |
| second_slot | input | 1 | 1 selects the second-operand code table |
| mode_code | input | 3 | Addressing-mode code |
| base_sel | input | 4 | Base register number |
| index_sel | input | 4 | Index register number |
| konst | input | 64 | Immediate, absolute address, pointer location or offset |
| scale_code | input | 2 | Index shift amount, 0 to 3 |
| disp | input | 64 | Displacement for displaced mode |
| rf_addr_a | output | 4 | Register read port A number |
| rf_addr_b | output | 4 | Register read port B number |
| rf_data_a | input | 64 | Register read port A data |
| rf_data_b | input | 64 | Register read port B data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Memory read address |
| mem_ready | input | 1 | Memory read served this cycle |
| mem_rdata | input | 64 | Memory read data |
| busy | output | 1 | Memory read in progress |
| done | output | 1 | Result valid pulse |
| illegal | output | 1 | Unusable mode code pulse |
| kind | output | 2 | 0 none, 1 value, 2 address |
| result | output | 64 | Operand value or address |

## Verification
All register-only and constant modes, and the illegal flag, are due exactly one cycle after the clock edge that accepts the start. The memory request appears at that same point. The done of a memory-indirect operand is due one cycle after the edge that samples `mem_ready` high. The bench changes inputs on falling edges, steps exactly one rising edge per expected register stage, and reads outputs at the next falling edge. It also reads one further cycle to confirm that each pulse has ended and that a start issued during a fetch produced nothing.

// File: rtl/oeag_pkg.sv
`timescale 1ns/1ps
package oeag_pkg;

    localparam int unsigned FIRST_MODE_W  = 2;
    localparam int unsigned SECOND_MODE_W = 3;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_VALUE = 2'd1,
        KIND_ADDR  = 2'd2
    } opnd_kind_e;

    typedef enum logic [3:0] {
        MD_IMPLIED,
        MD_IMM,
        MD_ABS,
        MD_REG,
        MD_IND,
        MD_PTR,
        MD_IDX,
        MD_SCA,
        MD_DIS,
        MD_BAD
    } opnd_mode_e;

    typedef enum logic {
        FS_IDLE,
        FS_WAIT
    } fetch_state_e;

    typedef struct packed {
        logic                     second_slot;
        logic [SECOND_MODE_W-1:0] code;
    } mode_sel_t;

    function automatic opnd_mode_e map_first(input logic [FIRST_MODE_W-1:0] c);
        opnd_mode_e m;
        case (c)
            2'd0:    m = MD_REG;
            2'd1:    m = MD_PTR;
            2'd2:    m = MD_IDX;
            default: m = MD_SCA;
        endcase
        return m;
    endfunction

    function automatic opnd_mode_e map_second(input logic [SECOND_MODE_W-1:0] c);
        opnd_mode_e m;
        case (c)
            3'd0:    m = MD_IMPLIED;
            3'd1:    m = MD_IMM;
            3'd2:    m = MD_ABS;
            3'd3:    m = MD_REG;
            3'd4:    m = MD_IND;
            3'd5:    m = MD_PTR;
            3'd6:    m = MD_IDX;
            default: m = MD_DIS;
        endcase
        return m;
    endfunction

    function automatic opnd_kind_e kind_of(input opnd_mode_e m);
        opnd_kind_e k;
        case (m)
            MD_IMM, MD_REG:                         k = KIND_VALUE;
            MD_ABS, MD_IND, MD_PTR, MD_IDX,
            MD_SCA, MD_DIS:                         k = KIND_ADDR;
            default:                                k = KIND_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/oeag_mode_decode.sv
`timescale 1ns/1ps
module oeag_mode_decode
    import oeag_pkg::*;
(
    input  mode_sel_t  sel,
    output opnd_mode_e mode
);
    // The first slot holds only the low code bits; anything above them is unusable.
    logic upper_set;
    assign upper_set = |sel.code[SECOND_MODE_W-1:FIRST_MODE_W];

    always_comb begin
        if (sel.second_slot) begin
            mode = map_second(sel.code);
        end else if (upper_set) begin
            mode = MD_BAD;
        end else begin
            mode = map_first(sel.code[FIRST_MODE_W-1:0]);
        end
    end
endmodule

// File: rtl/oeag_addr_calc.sv
`timescale 1ns/1ps
module oeag_addr_calc
    import oeag_pkg::*;
#(
    parameter int unsigned W         = 64,
    parameter int unsigned SCW       = 2,
    parameter bit          USE_SHIFT = 1'b1
) (
    input  opnd_mode_e     mode,
    input  logic [W-1:0]   base_val,
    input  logic [W-1:0]   index_val,
    input  logic [W-1:0]   konst,
    input  logic [W-1:0]   disp,
    input  logic [SCW-1:0] scale_code,
    output opnd_kind_e     kind,
    output logic [W-1:0]   value
);
    logic [W-1:0] scaled_idx;
    logic [W-1:0] base_plus_scaled;

    generate
        if (USE_SHIFT) begin : g_shift
            assign scaled_idx = index_val << scale_code;
        end else begin : g_mul
            logic [W-1:0] factor;
            assign factor     = W'(1) << scale_code;
            assign scaled_idx = index_val * factor;
        end
    endgenerate

    assign base_plus_scaled = base_val + scaled_idx;

    always_comb begin
        kind = kind_of(mode);
        case (mode)
            MD_IMM, MD_ABS: value = konst;
            MD_REG, MD_PTR: value = base_val;
            MD_IDX:         value = base_val + konst;
            MD_SCA:         value = base_plus_scaled;
            MD_DIS:         value = base_plus_scaled + disp;
            default:        value = '0;
        endcase
    end
endmodule

// File: rtl/oeag_mem_fetch.sv
`timescale 1ns/1ps
module oeag_mem_fetch
    import oeag_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         launch,
    input  logic [W-1:0] launch_addr,
    input  logic         mem_ready,
    input  logic [W-1:0] mem_rdata,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    output logic         busy,
    output logic         got,
    output logic [W-1:0] got_data
);
    fetch_state_e state_q;
    logic [W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            addr_q  <= '0;
        end else begin
            case (state_q)
                FS_IDLE: if (launch) begin
                    state_q <= FS_WAIT;
                    addr_q  <= launch_addr;
                end
                default: if (mem_ready) begin
                    state_q <= FS_IDLE;
                end
            endcase
        end
    end

    assign mem_req  = (state_q == FS_WAIT);
    assign mem_addr = addr_q;
    assign busy     = mem_req;
    assign got      = mem_req & mem_ready;
    assign got_data = mem_rdata;
endmodule

// File: rtl/operand_ea_gen.sv
`timescale 1ns/1ps
module operand_ea_gen
    import oeag_pkg::*;
#(
    parameter int unsigned W         = 64,
    parameter int unsigned NREG      = 16,
    parameter int unsigned SCALE_W   = 2,
    parameter bit          USE_SHIFT = 1'b1,
    localparam int unsigned RW       = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     second_slot,
    input  logic [SECOND_MODE_W-1:0] mode_code,
    input  logic [RW-1:0]            base_sel,
    input  logic [RW-1:0]            index_sel,
    input  logic [W-1:0]             konst,
    input  logic [SCALE_W-1:0]       scale_code,
    input  logic [W-1:0]             disp,
    output logic [RW-1:0]            rf_addr_a,
    output logic [RW-1:0]            rf_addr_b,
    input  logic [W-1:0]             rf_data_a,
    input  logic [W-1:0]             rf_data_b,
    output logic                     mem_req,
    output logic [W-1:0]             mem_addr,
    input  logic                     mem_ready,
    input  logic [W-1:0]             mem_rdata,
    output logic                     busy,
    output logic                     done,
    output logic                     illegal,
    output logic [1:0]               kind,
    output logic [W-1:0]             result
);
    mode_sel_t    sel;
    opnd_mode_e   mode;
    opnd_kind_e   calc_kind;
    logic [W-1:0] calc_value;
    logic         accept;
    logic         launch;
    logic         fetch_got;
    logic [W-1:0] fetch_data;

    logic         done_q;
    logic         illegal_q;
    opnd_kind_e   kind_q;
    logic [W-1:0] result_q;

    assign rf_addr_a = base_sel;
    assign rf_addr_b = index_sel;

    assign sel.second_slot = second_slot;
    assign sel.code        = mode_code;

    oeag_mode_decode u_decode (
        .sel  (sel),
        .mode (mode)
    );

    oeag_addr_calc #(
        .W         (W),
        .SCW       (SCALE_W),
        .USE_SHIFT (USE_SHIFT)
    ) u_calc (
        .mode       (mode),
        .base_val   (rf_data_a),
        .index_val  (rf_data_b),
        .konst      (konst),
        .disp       (disp),
        .scale_code (scale_code),
        .kind       (calc_kind),
        .value      (calc_value)
    );

    // A start is taken only while no pointer read is outstanding.
    assign accept = start & ~busy;
    assign launch = accept & (mode == MD_IND);

    oeag_mem_fetch #(
        .W (W)
    ) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_addr (konst),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .busy        (busy),
        .got         (fetch_got),
        .got_data    (fetch_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            kind_q    <= KIND_NONE;
            result_q  <= '0;
        end else begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            if (fetch_got) begin
                done_q   <= 1'b1;
                kind_q   <= KIND_ADDR;
                result_q <= fetch_data;
            end else if (accept) begin
                if (mode == MD_BAD) begin
                    illegal_q <= 1'b1;
                end else if (mode != MD_IND) begin
                    done_q   <= 1'b1;
                    kind_q   <= calc_kind;
                    result_q <= calc_value;
                end
            end
        end
    end

    assign done    = done_q;
    assign illegal = illegal_q;
    assign kind    = kind_q;
    assign result  = result_q;
endmodule

// File: rtl/operand_ea_gen_chk.sv
`timescale 1ns/1ps
module operand_ea_gen_chk #(
    parameter int unsigned W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         mem_req,
    input logic [W-1:0] mem_addr,
    input logic         mem_ready,
    input logic [W-1:0] mem_rdata,
    input logic         done,
    input logic         illegal,
    input logic [1:0]   kind,
    input logic [W-1:0] result
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !illegal && !mem_req && !busy));

    assert_implied_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (done && kind == 2'd0) |-> (result == '0));

    assert_fetch_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    assert_fetch_done_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready) |=> (done && kind == 2'd2 && result == $past(mem_rdata)));

    assert_bad_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !mem_req);

    assert_req_needs_start_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> ($past(start) && !$past(busy)));

    assert_pulse_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(done && illegal));
endmodule

bind operand_ea_gen operand_ea_gen_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .done      (done),
    .illegal   (illegal),
    .kind      (kind),
    .result    (result)
);

// File: tb/test_operand_ea_gen.sv
`timescale 1ns/1ps
module test_operand_ea_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        second_slot;
    logic [2:0]  mode_code;
    logic [3:0]  base_sel;
    logic [3:0]  index_sel;
    logic [63:0] konst;
    logic [1:0]  scale_code;
    logic [63:0] disp;
    logic [3:0]  rf_addr_a;
    logic [3:0]  rf_addr_b;
    logic [63:0] rf_data_a;
    logic [63:0] rf_data_b;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ready;
    logic [63:0] mem_rdata;
    logic        busy;
    logic        done;
    logic        illegal;
    logic [1:0]  kind;
    logic [63:0] result;

    logic [63:0] regs [16];
    int          total = 0;
    int          bad   = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    assign rf_data_a = regs[rf_addr_a];
    assign rf_data_b = regs[rf_addr_b];

    operand_ea_gen i_operand_ea_gen (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .second_slot (second_slot),
        .mode_code   (mode_code),
        .base_sel    (base_sel),
        .index_sel   (index_sel),
        .konst       (konst),
        .scale_code  (scale_code),
        .disp        (disp),
        .rf_addr_a   (rf_addr_a),
        .rf_addr_b   (rf_addr_b),
        .rf_data_a   (rf_data_a),
        .rf_data_b   (rf_data_b),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .done        (done),
        .illegal     (illegal),
        .kind        (kind),
        .result      (result)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives one start, steps one rising edge, returns at the next falling edge.
    task automatic issue(input logic slot, input logic [2:0] code, input logic [3:0] b,
                         input logic [3:0] x, input logic [63:0] k, input logic [1:0] sc,
                         input logic [63:0] d);
        second_slot = slot;
        mode_code   = code;
        base_sel    = b;
        index_sel   = x;
        konst       = k;
        scale_code  = sc;
        disp        = d;
        start       = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset_R1();
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 illegal", {63'd0, illegal}, 64'd0);
        check("R1 mem_req", {63'd0, mem_req}, 64'd0);
        check("R1 busy", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_implied_R3();
        issue(1'b1, 3'd0, 4'd3, 4'd4, 64'hFFFF, 2'd0, 64'd0);
        check("R3 done", {63'd0, done}, 64'd1);
        check("R3 kind", {62'd0, kind}, 64'd0);
        check("R3 result", result, 64'd0);
        @(posedge clk); @(negedge clk);
        check("R12 done ends", {63'd0, done}, 64'd0);
    endtask

    task automatic t_imm_abs_R4();
        issue(1'b1, 3'd1, 4'd0, 4'd0, 64'h0123_4567_89AB_CDEF, 2'd0, 64'd0);
        check("R4 imm done", {63'd0, done}, 64'd1);
        check("R4 imm kind", {62'd0, kind}, 64'd1);
        check("R4 imm result", result, 64'h0123_4567_89AB_CDEF);
        issue(1'b1, 3'd2, 4'd0, 4'd0, 64'h0000_0000_0000_1000, 2'd0, 64'd0);
        check("R4 abs kind", {62'd0, kind}, 64'd2);
        check("R4 abs result", result, 64'h1000);
    endtask

    task automatic t_reg_ptr_R5_R2();
        issue(1'b1, 3'd3, 4'd5, 4'd0, 64'd0, 2'd0, 64'd0);
        check("R5 reg kind", {62'd0, kind}, 64'd1);
        check("R5 reg result", result, regs[5]);
        issue(1'b1, 3'd5, 4'd6, 4'd0, 64'd0, 2'd0, 64'd0);
        check("R5 ptr kind", {62'd0, kind}, 64'd2);
        check("R5 ptr result", result, regs[6]);
        issue(1'b0, 3'd0, 4'd2, 4'd0, 64'd0, 2'd0, 64'd0);
        check("R2 first reg kind", {62'd0, kind}, 64'd1);
        check("R2 first reg result", result, regs[2]);
        issue(1'b0, 3'd1, 4'd9, 4'd0, 64'd0, 2'd0, 64'd0);
        check("R2 first ptr kind", {62'd0, kind}, 64'd2);
        check("R2 first ptr result", result, regs[9]);
    endtask

    task automatic t_indexed_R6();
        issue(1'b1, 3'd6, 4'd7, 4'd0, 64'hFFFF_FFFF_FFFF_FFF8, 2'd0, 64'd0);
        check("R6 kind", {62'd0, kind}, 64'd2);
        check("R6 negative offset", result, regs[7] - 64'd8);
        issue(1'b0, 3'd2, 4'd15, 4'd0, 64'h40, 2'd0, 64'd0);
        check("R6 wrap first slot", result, 64'h30);
    endtask

    task automatic t_scaled_R7();
        for (int s = 0; s < 4; s++) begin
            issue(1'b0, 3'd3, 4'd1, 4'd3, 64'd0, 2'(s), 64'd0);
            check($sformatf("R7 scale %0d", s), result, regs[1] + regs[3] * (64'd1 << s));
            check("R7 kind", {62'd0, kind}, 64'd2);
        end
    endtask

    task automatic t_displaced_R8();
        issue(1'b1, 3'd7, 4'd15, 4'd2, 64'd0, 2'd3, 64'h20);
        check("R8 wrap", result, 64'hFFFF_FFFF_FFFF_FFF0 + regs[2] * 64'd8 + 64'h20);
        check("R8 kind", {62'd0, kind}, 64'd2);
        issue(1'b1, 3'd7, 4'd4, 4'd4, 64'd0, 2'd1, 64'h1_0000_0000);
        check("R8 plain", result, regs[4] * 64'd3 + 64'h1_0000_0000);
    endtask

    task automatic t_indirect_R9_R11();
        issue(1'b1, 3'd4, 4'd0, 4'd0, 64'h0000_0000_0000_2000, 2'd0, 64'd0);
        check("R9 req raised", {63'd0, mem_req}, 64'd1);
        check("R9 req addr", mem_addr, 64'h2000);
        check("R9 no early done", {63'd0, done}, 64'd0);
        check("R11 busy", {63'd0, busy}, 64'd1);
        issue(1'b1, 3'd1, 4'd0, 4'd0, 64'h55, 2'd0, 64'd0);
        check("R11 start ignored done", {63'd0, done}, 64'd0);
        check("R11 req kept", {63'd0, mem_req}, 64'd1);
        check("R11 addr kept", mem_addr, 64'h2000);
        mem_ready = 1'b1;
        mem_rdata = 64'hDEAD_BEEF_0000_1234;
        @(posedge clk); @(negedge clk);
        mem_ready = 1'b0;
        check("R9 done", {63'd0, done}, 64'd1);
        check("R9 kind", {62'd0, kind}, 64'd2);
        check("R9 result", result, 64'hDEAD_BEEF_0000_1234);
        check("R9 req dropped", {63'd0, mem_req}, 64'd0);
        @(posedge clk); @(negedge clk);
        check("R12 fetch done ends", {63'd0, done}, 64'd0);
    endtask

    task automatic t_illegal_R10();
        for (int c = 4; c < 8; c++) begin
            issue(1'b0, 3'(c), 4'd1, 4'd1, 64'h3000, 2'd0, 64'd0);
            check($sformatf("R10 flag code %0d", c), {63'd0, illegal}, 64'd1);
            check("R10 no done", {63'd0, done}, 64'd0);
            check("R10 no request", {63'd0, mem_req}, 64'd0);
            @(posedge clk); @(negedge clk);
            check("R12 illegal ends", {63'd0, illegal}, 64'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            regs[i] = {32'hA5A5_0000 + 32'(i), 32'h0000_1000 * 32'(i + 1)};
        end
        regs[15] = 64'hFFFF_FFFF_FFFF_FFF0;
        rst = 1'b1; start = 1'b0; second_slot = 1'b0; mode_code = '0;
        base_sel = '0; index_sel = '0; konst = '0; scale_code = '0; disp = '0;
        mem_ready = 1'b0; mem_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_R1();
        t_implied_R3();
        t_imm_abs_R4();
        t_reg_ptr_R5_R2();
        t_indexed_R6();
        t_scaled_R7();
        t_displaced_R8();
        t_indirect_R9_R11();
        t_illegal_R10();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule